// File: doc/BRIEF.md
# Status channel frame synchronizer

This block watches the two-bit status lane that runs back from a packet receiver to its sender on the status clock. The lane carries a repeating stream. Each frame starts with a framing word. The framing word is followed by one two-bit status entry per calendar slot, and the calendar is repeated a fixed number of times. A two-bit check word closes the frame. The block follows this stream word by word and checks every frame's check word. From that history it decides whether the link is locked (in frame) or lost (out of frame).

For the sender's scheduler, the block keeps a table with one two-bit status per channel. The table takes new values only from frames that arrived whole and checked good while the link was locked. While the link is reported lost, every channel reads as starving (00). The block gives a one-cycle pulse for each bad check word and for each misplaced framing word. An enable input turns checking on and off. An override input makes the block report lock regardless of the lane, which is useful for bring-up.

Top module: `stat_frame_sync`

## Requirements
- R1: While `rst_n` is low, and on release, `out_of_frame_o` is 1, both pulse outputs are 0 and `chan_status_o` is all zero. The reset acts asynchronously.
- R2: The framing word is 2'b11. After it come NUM_CHAN*CAL_REP entries, which belong to channels 0,1,…,NUM_CHAN-1 in turn, repeated CAL_REP times. Then comes one check word, and the next word must be a framing word. An 2'b11 seen while entries are expected restarts the frame. Words seen before the first framing word are ignored.
- R3: The expected check word is the bitwise XOR of all the frame's entries. When the received check word differs, `dip_err_o` is high for exactly one cycle, in the cycle after the check word is sampled.
- R4: ERR_LIMIT consecutive bad check words set `out_of_frame_o`.
- R5: With `enable_i` high, MATCH_LIMIT consecutive good check words clear `out_of_frame_o`. A bad check word, a framing error or a run of four framing words restarts this count.
- R6: Four consecutive 2'b11 words, with enable high, set `out_of_frame_o` in the cycle after the fourth word.
- R7: A word other than 2'b11 right after a check word raises `frame_err_o` for one cycle. The block then searches for the next framing word.
- R8: With `enable_i` low, `out_of_frame_o` is held at 1 (unless overridden), both pulse outputs stay 0, the table is not written and alignment is dropped.
- R9: While `override_i` is high, `out_of_frame_o` is 0 whatever arrives on `stat_i`. Good frames then update the table.
- R10: Channel c's status appears on `chan_status_o[2c+1:2c]`. It takes its value from the last entry for c in a frame whose check word was good while the link was locked or overridden. Whenever `out_of_frame_o` is 1, `chan_status_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Status clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Enables checking and lock acquisition |
| override_i | input | 1 | Forces the in-frame report |
| stat_i | input | 2 | Received status lane word |
| chan_status_o | output | 2*NUM_CHAN | Per-channel status table |
| out_of_frame_o | output | 1 | Link not locked |
| dip_err_o | output | 1 | One-cycle pulse on a check word mismatch |
| frame_err_o | output | 1 | One-cycle pulse on a missing framing word after a check word |

## Verification
The hardest state to reach from the ports is a run of framing words that meets the frame boundary. There, the four-word loss rule and the frame restart act in the same cycle as a restart of the match count. A clean run of frames never produces this. The bench drives directed runs of four or more 2'b11 words right after a check word. It then mixes random runs, corrupted check words, missing framing words and enable/override toggles into a seeded random frame stream. A bench model predicts every output on every cycle.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
    typedef enum logic [1:0] {
        PH_HUNT  = 2'd0,
        PH_ENTRY = 2'd1,
        PH_DIP   = 2'd2,
        PH_SYNC  = 2'd3
    } sfs_phase_e;

    localparam logic [1:0] SFS_FRAME_WORD = 2'b11;
endpackage

// File: rtl/sfs_dip_acc.sv
module sfs_dip_acc (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       add_i,
    input  logic [1:0] word_i,
    output logic [1:0] acc_o
);
    logic [1:0] acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (clear_i) begin
            acc_d = 2'b00;
        end else if (add_i) begin
            acc_d = acc_q ^ word_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= 2'b00;
        else        acc_q <= acc_d;
    end

    assign acc_o = acc_q;
endmodule

// File: rtl/sfs_lock.sv
module sfs_lock #(
    parameter int ERR_LIMIT   = 2,
    parameter int MATCH_LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic dip_ok_i,
    input  logic dip_bad_i,
    input  logic run4_i,
    input  logic realign_i,
    output logic oof_o,
    output logic dip_err_o
);
    localparam int BW = $clog2(ERR_LIMIT + 1);
    localparam int GW = $clog2(MATCH_LIMIT + 1);

    typedef struct packed {
        logic          oof;
        logic [BW-1:0] bad;
        logic [GW-1:0] good;
        logic          dip_err;
    } lock_t;

    lock_t lk_d, lk_q;

    always_comb begin
        lk_d         = lk_q;
        lk_d.dip_err = 1'b0;
        if (!enable_i) begin
            lk_d.oof  = 1'b1;
            lk_d.bad  = '0;
            lk_d.good = '0;
        end else begin
            if (dip_bad_i) begin
                lk_d.dip_err = 1'b1;
                lk_d.good    = '0;
                if (lk_q.bad >= BW'(ERR_LIMIT - 1)) begin
                    lk_d.bad = BW'(ERR_LIMIT);
                    lk_d.oof = 1'b1;
                end else begin
                    lk_d.bad = lk_q.bad + 1'b1;
                end
            end
            if (dip_ok_i) begin
                lk_d.bad = '0;
                if (lk_q.good >= GW'(MATCH_LIMIT - 1)) begin
                    lk_d.good = GW'(MATCH_LIMIT);
                    lk_d.oof  = 1'b0;
                end else begin
                    lk_d.good = lk_q.good + 1'b1;
                end
            end
            if (realign_i) begin
                lk_d.good = '0;
            end
            if (run4_i) begin
                lk_d.oof  = 1'b1;
                lk_d.good = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_q     <= '0;
            lk_q.oof <= 1'b1;
        end else begin
            lk_q <= lk_d;
        end
    end

    assign oof_o     = lk_q.oof;
    assign dip_err_o = lk_q.dip_err;
endmodule

// File: rtl/sfs_chan_table.sv
module sfs_chan_table #(
    parameter int NUM_CHAN = 4,
    parameter int CH_W     = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_i,
    input  logic [CH_W-1:0]       chan_i,
    input  logic [1:0]            word_i,
    input  logic                  commit_i,
    output logic [2*NUM_CHAN-1:0] table_o
);
    typedef struct packed {
        logic [2*NUM_CHAN-1:0] shadow;
        logic [2*NUM_CHAN-1:0] tbl;
    } tab_t;

    tab_t tb_d, tb_q;

    always_comb begin
        tb_d = tb_q;
        if (wr_i) begin
            tb_d.shadow[2*int'(chan_i) +: 2] = word_i;
        end
        if (commit_i) begin
            tb_d.tbl = tb_q.shadow;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_d;
    end

    assign table_o = tb_q.tbl;
endmodule

// File: rtl/stat_frame_sync.sv
module stat_frame_sync
    import sfs_pkg::*;
#(
    parameter int NUM_CHAN    = 4,
    parameter int CAL_REP     = 2,
    parameter int ERR_LIMIT   = 2,
    parameter int MATCH_LIMIT = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable_i,
    input  logic                  override_i,
    input  logic [1:0]            stat_i,
    output logic [2*NUM_CHAN-1:0] chan_status_o,
    output logic                  out_of_frame_o,
    output logic                  dip_err_o,
    output logic                  frame_err_o
);
    localparam int ENTRIES = NUM_CHAN * CAL_REP;
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int CH_W    = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1;

    typedef struct packed {
        sfs_phase_e       phase;
        logic [IDX_W-1:0] idx;
        logic [CH_W-1:0]  chan;
        logic [2:0]       ones;
        logic             frame_err;
    } seq_t;

    seq_t seq_d, seq_q;

    logic                  is_frame;
    logic                  frame_start;
    logic                  entry_we;
    logic                  dip_ok;
    logic                  dip_bad;
    logic                  run4;
    logic                  realign;
    logic                  commit;
    logic                  oof_q;
    logic [1:0]            acc;
    logic [2*NUM_CHAN-1:0] table_w;

    assign is_frame = (stat_i == SFS_FRAME_WORD);
    assign run4     = enable_i && is_frame && (seq_q.ones >= 3'd3);

    always_comb begin
        seq_d           = seq_q;
        seq_d.frame_err = 1'b0;
        frame_start     = 1'b0;
        entry_we        = 1'b0;
        dip_ok          = 1'b0;
        dip_bad         = 1'b0;
        realign         = 1'b0;
        if (!enable_i) begin
            seq_d.phase = PH_HUNT;
            seq_d.idx   = '0;
            seq_d.chan  = '0;
            seq_d.ones  = '0;
        end else begin
            if (is_frame) begin
                seq_d.ones = (seq_q.ones == 3'd4) ? 3'd4 : seq_q.ones + 3'd1;
            end else begin
                seq_d.ones = '0;
            end
            case (seq_q.phase)
                PH_HUNT: begin
                    frame_start = is_frame;
                end
                PH_ENTRY: begin
                    if (is_frame) begin
                        frame_start = 1'b1;
                    end else begin
                        entry_we = 1'b1;
                        if (seq_q.idx == IDX_W'(ENTRIES - 1)) begin
                            seq_d.phase = PH_DIP;
                        end else begin
                            seq_d.idx = seq_q.idx + 1'b1;
                        end
                        if (seq_q.chan == CH_W'(NUM_CHAN - 1)) begin
                            seq_d.chan = '0;
                        end else begin
                            seq_d.chan = seq_q.chan + 1'b1;
                        end
                    end
                end
                PH_DIP: begin
                    dip_ok      = (stat_i == acc);
                    dip_bad     = (stat_i != acc);
                    seq_d.phase = PH_SYNC;
                end
                PH_SYNC: begin
                    if (is_frame) begin
                        frame_start = 1'b1;
                    end else begin
                        seq_d.frame_err = 1'b1;
                        realign         = 1'b1;
                        seq_d.phase     = PH_HUNT;
                    end
                end
                default: seq_d.phase = PH_HUNT;
            endcase
            if (frame_start) begin
                seq_d.phase = PH_ENTRY;
                seq_d.idx   = '0;
                seq_d.chan  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    sfs_dip_acc acc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (frame_start),
        .add_i   (entry_we),
        .word_i  (stat_i),
        .acc_o   (acc)
    );

    sfs_lock #(
        .ERR_LIMIT   (ERR_LIMIT),
        .MATCH_LIMIT (MATCH_LIMIT)
    ) lock_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (enable_i),
        .dip_ok_i  (dip_ok),
        .dip_bad_i (dip_bad),
        .run4_i    (run4),
        .realign_i (realign),
        .oof_o     (oof_q),
        .dip_err_o (dip_err_o)
    );

    assign commit = dip_ok && (!oof_q || override_i);

    sfs_chan_table #(
        .NUM_CHAN (NUM_CHAN),
        .CH_W     (CH_W)
    ) table_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (entry_we),
        .chan_i   (seq_q.chan),
        .word_i   (stat_i),
        .commit_i (commit),
        .table_o  (table_w)
    );

    assign out_of_frame_o = oof_q && !override_i;
    assign chan_status_o  = out_of_frame_o ? '0 : table_w;
    assign frame_err_o    = seq_q.frame_err;
endmodule

// File: rtl/sfs_checker.sv
module sfs_checker #(
    parameter int NUM_CHAN = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  enable_i,
    input logic                  override_i,
    input logic [1:0]            stat_i,
    input logic [2*NUM_CHAN-1:0] chan_status_o,
    input logic                  out_of_frame_o,
    input logic                  dip_err_o,
    input logic                  frame_err_o
);
    logic [2:0] cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cyc_q <= '0;
        else if (cyc_q != 3'd7)  cyc_q <= cyc_q + 3'd1;
    end

    // R3
    dip_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dip_err_o |=> !dip_err_o);

    // R7
    frame_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |=> !frame_err_o);

    // R8
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (!dip_err_o && !frame_err_o));

    // R8
    disabled_oof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (out_of_frame_o || override_i));

    // R9
    override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        override_i |-> !out_of_frame_o);

    // R10
    blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_of_frame_o |-> (chan_status_o == '0));

    // R6
    four_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 3'd3 && enable_i && stat_i == 2'b11
         && $past(stat_i) == 2'b11 && $past(stat_i, 2) == 2'b11 && $past(stat_i, 3) == 2'b11
         && $past(enable_i) && $past(enable_i, 2) && $past(enable_i, 3))
        |=> (out_of_frame_o || override_i));
endmodule

bind stat_frame_sync sfs_checker #(.NUM_CHAN(NUM_CHAN)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .enable_i       (enable_i),
    .override_i     (override_i),
    .stat_i         (stat_i),
    .chan_status_o  (chan_status_o),
    .out_of_frame_o (out_of_frame_o),
    .dip_err_o      (dip_err_o),
    .frame_err_o    (frame_err_o)
);

// File: tb/stat_frame_sync_tb_top.sv
module stat_frame_sync_tb_top;
    localparam int NUM_CHAN    = 4;
    localparam int CAL_REP     = 2;
    localparam int ERR_LIMIT   = 2;
    localparam int MATCH_LIMIT = 3;
    localparam int ENTRIES     = NUM_CHAN * CAL_REP;

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic                  en;
    logic                  ov;
    logic [1:0]            stat;
    logic [2*NUM_CHAN-1:0] chan_status;
    logic                  oof;
    logic                  dip_err;
    logic                  frame_err;

    stat_frame_sync #(
        .NUM_CHAN    (NUM_CHAN),
        .CAL_REP     (CAL_REP),
        .ERR_LIMIT   (ERR_LIMIT),
        .MATCH_LIMIT (MATCH_LIMIT)
    ) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .enable_i       (en),
        .override_i     (ov),
        .stat_i         (stat),
        .chan_status_o  (chan_status),
        .out_of_frame_o (oof),
        .dip_err_o      (dip_err),
        .frame_err_o    (frame_err)
    );

    always #10 clk = ~clk;

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R1";

    // reference state, phases: 0 hunt, 1 entries, 2 check word, 3 framing expected
    int                    m_phase, m_idx, m_good, m_bad, m_ones;
    logic [1:0]            m_acc;
    logic                  m_oof, m_dip_err, m_frame_err;
    logic [2*NUM_CHAN-1:0] m_shadow, m_table;

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", cur_req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_phase = 0; m_idx = 0; m_good = 0; m_bad = 0; m_ones = 0;
        m_acc = 2'b00; m_oof = 1'b1; m_dip_err = 1'b0; m_frame_err = 1'b0;
        m_shadow = '0; m_table = '0;
    endtask

    task automatic model_step(logic [1:0] w);
        logic run4, locked, start;
        m_dip_err = 1'b0;
        m_frame_err = 1'b0;
        if (!en) begin
            m_phase = 0; m_idx = 0; m_good = 0; m_bad = 0; m_ones = 0; m_oof = 1'b1;
            return;
        end
        run4   = (w == 2'b11) && (m_ones >= 3);
        m_ones = (w == 2'b11) ? m_ones + 1 : 0;
        locked = !m_oof || ov;
        start  = 1'b0;
        case (m_phase)
            0: start = (w == 2'b11);
            1: begin
                if (w == 2'b11) start = 1'b1;
                else begin
                    m_shadow[2*(m_idx % NUM_CHAN) +: 2] = w;
                    m_acc = m_acc ^ w;
                    if (m_idx == ENTRIES - 1) m_phase = 2;
                    else m_idx++;
                end
            end
            2: begin
                if (w == m_acc) begin
                    m_bad = 0; m_good++;
                    if (m_good >= MATCH_LIMIT) m_oof = 1'b0;
                    if (locked) m_table = m_shadow;
                end else begin
                    m_dip_err = 1'b1; m_good = 0; m_bad++;
                    if (m_bad >= ERR_LIMIT) m_oof = 1'b1;
                end
                m_phase = 3;
            end
            default: begin
                if (w == 2'b11) start = 1'b1;
                else begin
                    m_frame_err = 1'b1; m_good = 0; m_phase = 0;
                end
            end
        endcase
        if (start) begin
            m_phase = 1; m_idx = 0; m_acc = 2'b00;
        end
        if (run4) begin
            m_oof = 1'b1; m_good = 0;
        end
    endtask

    task automatic step(logic [1:0] w);
        logic exp_oof;
        stat = w;
        @(posedge clk);
        @(negedge clk);
        model_step(w);
        exp_oof = m_oof && !ov;
        chk("out_of_frame", 32'(oof), 32'(exp_oof));
        chk("dip_err", 32'(dip_err), 32'(m_dip_err));
        chk("frame_err", 32'(frame_err), 32'(m_frame_err));
        chk("chan_status", 32'(chan_status), exp_oof ? 32'd0 : 32'(m_table));
    endtask

    // kind: 0 good, 1 corrupted check word, 2 missing framing word after check word
    task automatic send_frame(int kind);
        logic [1:0] acc, w;
        acc = 2'b00;
        step(2'b11);
        for (int i = 0; i < ENTRIES; i++) begin
            w = 2'($urandom % 3);
            acc = acc ^ w;
            step(w);
        end
        if (kind == 1) step(acc ^ 2'(1 + $urandom % 3));
        else step(acc);
        if (kind == 2) step(2'($urandom % 3));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; en = 1'b0; ov = 1'b0; stat = 2'b11;
        model_reset();
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk("reset oof", 32'(oof), 32'd1);
        chk("reset table", 32'(chan_status), 32'd0);
        chk("reset pulses", 32'({dip_err, frame_err}), 32'd0);
        rst_n = 1'b1;
        en = 1'b1;

        cur_req = "R2";
        step(2'b01); step(2'b11); step(2'b11);
        send_frame(0); send_frame(0);
        chk("not yet locked", 32'(oof), 32'd1);
        cur_req = "R5";
        send_frame(0);
        chk("locked after matches", 32'(oof), 32'd0);

        cur_req = "R10";
        send_frame(0); send_frame(0);
        chk("table from last good frame", 32'(chan_status), 32'(m_table));

        cur_req = "R3";
        send_frame(1);
        chk("single bad keeps lock", 32'(oof), 32'd0);
        send_frame(0);

        cur_req = "R4";
        send_frame(1); send_frame(1);
        chk("lock lost after bad run", 32'(oof), 32'd1);
        chk("table blanked", 32'(chan_status), 32'd0);
        cur_req = "R5";
        repeat (3) send_frame(0);
        chk("relocked", 32'(oof), 32'd0);

        cur_req = "R6";
        step(2'b11); step(2'b11); step(2'b11); step(2'b11);
        chk("four framing words drop lock", 32'(oof), 32'd1);
        repeat (3) send_frame(0);
        chk("relock after run", 32'(oof), 32'd0);

        cur_req = "R7";
        send_frame(0);
        step(2'b10);
        chk("missing framing word", 32'(frame_err), 32'd1);
        step(2'b00);
        chk("frame error pulse ends", 32'(frame_err), 32'd0);

        cur_req = "R8";
        en = 1'b0;
        send_frame(1); send_frame(0);
        chk("disabled oof", 32'(oof), 32'd1);
        chk("disabled no pulse", 32'({dip_err, frame_err}), 32'd0);
        en = 1'b1;
        repeat (3) send_frame(0);

        cur_req = "R9";
        ov = 1'b1;
        send_frame(1); send_frame(1); step(2'b11); step(2'b11); step(2'b11); step(2'b11);
        chk("override reports lock", 32'(oof), 32'd0);
        send_frame(0);
        chk("override table update", 32'(chan_status), 32'(m_table));
        ov = 1'b0;

        cur_req = "R2";
        for (int it = 0; it < 2000; it++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 80) send_frame(0);
            else if (r < 88) send_frame(1);
            else if (r < 92) send_frame(2);
            else if (r < 95) begin
                for (int k = 0; k < 3 + int'($urandom % 4); k++) step(2'b11);
            end else if (r < 97) en = ~en;
            else if (r < 99) ov = ~ov;
            else step(2'($urandom % 4));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule